// File: doc/BRIEF.md
# Sparsifying Cluster Finder with 2x2 Kernel and 7x7 Readout Windows

The block sits behind a bank of column-parallel 5-bit converters. It receives one full row of pixel values per strobe, with every column presented side by side. It evaluates a 2x2 summing kernel at every position in the row pair it has most recently seen. Each kernel sum is compared against a single threshold that all positions share. A firing kernel marks a 7x7 neighbourhood for readout. The marks of neighbouring hits merge into one mask.

Rows are held in a short line buffer. This gives hits found in later rows time to mark pixels above them. Once a row can no longer gain marks, its marked pixels are written one per cycle into an output FIFO as packed words. Each word carries the row, the column and the raw value. Unmarked pixels are dropped. A frame is a fixed number of rows. After the last row of a frame arrives, the block drains its final buffered rows without further input. A full FIFO drops words and counts them in a saturating counter.

Top module: `cf_cluster_finder`

## Requirements
- R1: While reset is asserted and directly after it is released, `empty_o` is 1 and `overflow_cnt_o` is 0.
- R2: A kernel anchored at (r,c) covers rows r and r+1 and columns c and c+1. It fires only when the sum of its four pixels is strictly greater than `threshold_i`. A sum equal to the threshold does not fire.
- R3: A kernel firing at anchor (r,c) marks every pixel in rows r-3..r+3 and columns c-3..c+3, which is 49 pixels away from the edges.
- R4: Marked windows are clipped at the array edges. Kernel anchors exist only for c up to NUM_COLS-2 and r up to NUM_ROWS-2.
- R5: The marks of overlapping windows are merged, so each pixel of a frame is output at most once.
- R6: An output word holds the row in bits [12:9], the column in bits [8:5] and the pixel value in bits [4:0] (default parameters). Words leave in ascending row order, and in ascending column order within a row.
- R7: A pixel that no window marks never appears at the output. A frame without hits produces no words.
- R8: Kernels never combine rows of two different frames.
- R9: When the FIFO is full, new words are dropped and `overflow_cnt_o` increments by one per dropped word, saturating at its maximum. Words already stored are kept.
- R10: The first strobe of a frame is row 0. After row NUM_ROWS-1, the last four rows are emitted with no further input. Strobes must be at least NUM_COLS+1 cycles apart, and no strobe may arrive during the drain.
- R11: While `empty_o` is 0, `rd_data_o` shows the oldest stored word, and `rd_en_i` removes it at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| row_valid_i | input | 1 | Strobe: `row_data_i` holds the next row of the frame |
| row_data_i | input | 80 | Row of pixels, column 0 in bits [4:0] |
| threshold_i | input | 7 | Threshold for the kernel sum |
| rd_en_i | input | 1 | Pop the oldest FIFO word |
| rd_data_o | output | 13 | Oldest FIFO word {row, column, value} |
| empty_o | output | 1 | FIFO holds no word |
| overflow_cnt_o | output | 4 | Saturating count of dropped words |

## Verification
A wrong line-buffer shift or a stale mark shows up as a word with the wrong value, a missing word or an extra word. This becomes visible four row strobes after the row that caused it. Frames with a hit placed exactly at the threshold, hits at the corners and overlapping windows expose errors in the mask arithmetic as wrong word counts at the end of the frame. A broken scan order shows up at once as an out-of-order word. A mis-handled full FIFO shows up in the stored words and in the drop count once the FIFO is read.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int unsigned CF_HALO = 3;  // window reach on each side of an anchor
  localparam int unsigned CF_LAG  = 4;  // rows between arrival and emission
endpackage

// File: rtl/cf_kernel.sv
module cf_kernel #(
  parameter int unsigned NUM_COLS = 16,
  parameter int unsigned PIX_W    = 5,
  localparam int unsigned SUM_W   = PIX_W + 2
) (
  input  logic [NUM_COLS*PIX_W-1:0] prev_row_i,
  input  logic [NUM_COLS*PIX_W-1:0] cur_row_i,
  input  logic [SUM_W-1:0]          thr_i,
  input  logic                      en_i,
  output logic [NUM_COLS-2:0]       hit_o,
  output logic [NUM_COLS-1:0]       mask_o
);
  import cf_pkg::*;

  for (genvar c = 0; c < NUM_COLS - 1; c++) begin : g_pos
    logic [SUM_W-1:0] sum;
    always_comb begin
      sum = SUM_W'(prev_row_i[c*PIX_W +: PIX_W]) + SUM_W'(prev_row_i[(c+1)*PIX_W +: PIX_W])
          + SUM_W'(cur_row_i[c*PIX_W +: PIX_W])  + SUM_W'(cur_row_i[(c+1)*PIX_W +: PIX_W]);
    end
    assign hit_o[c] = en_i && (sum > thr_i);
  end

  always_comb begin
    mask_o = '0;
    for (int j = 0; j < int'(NUM_COLS); j++) begin
      for (int c = 0; c < int'(NUM_COLS) - 1; c++) begin
        if (hit_o[c] && (c + int'(CF_HALO) >= j) && (j + int'(CF_HALO) >= c)) mask_o[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cf_scan.sv
module cf_scan #(
  parameter int unsigned NUM_COLS = 16,
  parameter int unsigned PIX_W    = 5,
  parameter int unsigned ROW_W    = 4,
  localparam int unsigned COL_W   = $clog2(NUM_COLS),
  localparam int unsigned WORD_W  = ROW_W + COL_W + PIX_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [ROW_W-1:0]          load_row_i,
  input  logic [NUM_COLS-1:0]       load_mask_i,
  input  logic [NUM_COLS*PIX_W-1:0] load_data_i,
  output logic                      busy_o,
  output logic                      push_o,
  output logic [WORD_W-1:0]         word_o
);
  logic [NUM_COLS-1:0]       mask_q;
  logic [NUM_COLS*PIX_W-1:0] data_q;
  logic [ROW_W-1:0]          row_q;
  logic [COL_W-1:0]          sel;

  always_comb begin
    sel = '0;
    for (int j = int'(NUM_COLS) - 1; j >= 0; j--) begin
      if (mask_q[j]) sel = COL_W'(j);
    end
  end

  assign busy_o = |mask_q;
  assign push_o = busy_o;
  assign word_o = {row_q, sel, data_q[sel*PIX_W +: PIX_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      data_q <= '0;
      row_q  <= '0;
    end else if (load_i) begin
      mask_q <= load_mask_i;
      data_q <= load_data_i;
      row_q  <= load_row_i;
    end else if (busy_o) begin
      mask_q[sel] <= 1'b0;
    end
  end

  AST_LOAD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o); // R10
  AST_COL_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && $past(push_o) && !$past(load_i) && word_o[WORD_W-1 -: ROW_W] == $past(word_o[WORD_W-1 -: ROW_W]))
      |-> word_o[PIX_W +: COL_W] > $past(word_o[PIX_W +: COL_W])); // R6
endmodule

// File: rtl/cf_fifo.sv
module cf_fifo #(
  parameter int unsigned WORD_W = 13,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned OVF_W  = 4,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic [OVF_W-1:0]  ovf_cnt_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [AW:0]       cnt_q;
  logic              full, do_push, do_pop;

  assign full      = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign do_push   = push_i && !full;
  assign do_pop    = rd_en_i && !empty_o;
  assign rd_data_o = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      cnt_q     <= '0;
      ovf_cnt_o <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wptr_q] <= word_i;
        wptr_q        <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      end
      if (do_pop) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
      if (push_i && full && ovf_cnt_o != '1) ovf_cnt_o <= ovf_cnt_o + 1'b1;
    end
  end

  AST_OVF_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_cnt_o >= $past(ovf_cnt_o)); // R9
  AST_OVF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && ovf_cnt_o != '1) |=> ovf_cnt_o == $past(ovf_cnt_o) + 1'b1); // R9
  AST_FULL_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !rd_en_i) |=> (!empty_o && $stable(rd_data_o))); // R9
endmodule

// File: rtl/cf_cluster_finder.sv
module cf_cluster_finder #(
  parameter int unsigned NUM_COLS   = 16,
  parameter int unsigned NUM_ROWS   = 16,
  parameter int unsigned PIX_W      = 5,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned OVF_W      = 4,
  localparam int unsigned ROW_W     = $clog2(NUM_ROWS),
  localparam int unsigned COL_W     = $clog2(NUM_COLS),
  localparam int unsigned WORD_W    = ROW_W + COL_W + PIX_W,
  localparam int unsigned THR_W     = PIX_W + 2,
  localparam int unsigned ROW_BITS  = NUM_COLS * PIX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                row_valid_i,
  input  logic [ROW_BITS-1:0] row_data_i,
  input  logic [THR_W-1:0]    threshold_i,
  input  logic                rd_en_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic                empty_o,
  output logic [OVF_W-1:0]    overflow_cnt_o
);
  import cf_pkg::*;

  localparam int unsigned NFLG   = 2 * CF_HALO;             // mark rows kept ahead of emission
  localparam int unsigned STEPS  = NUM_ROWS + CF_LAG;       // steps per frame
  localparam int unsigned STEP_W = $clog2(STEPS);

  logic [ROW_BITS-1:0] dbuf_q [CF_LAG];   // rows s-4 .. s-1
  logic [NUM_COLS-1:0] flg_q  [NFLG];     // marks for rows s-4 .. s+1
  logic [STEP_W-1:0]   step_q;

  logic                in_frame, step, kern_en, emit_en, scan_busy, scan_push;
  logic [ROW_BITS-1:0] new_row;
  logic [NUM_COLS-2:0] hit;
  logic [NUM_COLS-1:0] mask;
  logic [NUM_COLS-1:0] base_flg [NFLG];
  logic [NUM_COLS-1:0] emit_mask;
  logic [ROW_W-1:0]    emit_row;
  logic [WORD_W-1:0]   scan_word;

  assign in_frame = (step_q < STEP_W'(NUM_ROWS));
  // drain steps wait for the scanner so no emitted row is lost
  assign step     = in_frame ? row_valid_i : !scan_busy;
  assign kern_en  = in_frame && (step_q != '0);
  assign emit_en  = (step_q >= STEP_W'(CF_LAG));
  assign new_row  = in_frame ? row_data_i : '0;
  assign emit_row = ROW_W'(step_q - STEP_W'(CF_LAG));

  always_comb begin
    for (int i = 0; i < int'(NFLG); i++) base_flg[i] = (step_q == '0) ? '0 : flg_q[i];
  end
  assign emit_mask = base_flg[0] | mask;

  cf_kernel #(.NUM_COLS(NUM_COLS), .PIX_W(PIX_W)) i_kernel (
    .prev_row_i (dbuf_q[CF_LAG-1]),
    .cur_row_i  (new_row),
    .thr_i      (threshold_i),
    .en_i       (kern_en),
    .hit_o      (hit),
    .mask_o     (mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      for (int i = 0; i < int'(CF_LAG); i++) dbuf_q[i] <= '0;
      for (int i = 0; i < int'(NFLG); i++)   flg_q[i]  <= '0;
    end else if (step) begin
      step_q <= (step_q == STEP_W'(STEPS - 1)) ? '0 : step_q + 1'b1;
      for (int i = 0; i < int'(CF_LAG) - 1; i++) dbuf_q[i] <= dbuf_q[i+1];
      dbuf_q[CF_LAG-1] <= new_row;
      for (int i = 0; i < int'(NFLG) - 1; i++) flg_q[i] <= base_flg[i+1] | mask;
      flg_q[NFLG-1] <= mask;
    end
  end

  cf_scan #(.NUM_COLS(NUM_COLS), .PIX_W(PIX_W), .ROW_W(ROW_W)) i_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (step && emit_en),
    .load_row_i  (emit_row),
    .load_mask_i (emit_mask),
    .load_data_i (dbuf_q[0]),
    .busy_o      (scan_busy),
    .push_o      (scan_push),
    .word_o      (scan_word)
  );

  cf_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH), .OVF_W(OVF_W)) i_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (scan_push),
    .word_i    (scan_word),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .empty_o   (empty_o),
    .ovf_cnt_o (overflow_cnt_o)
  );

  AST_NO_ROW_IN_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_valid_i |-> in_frame); // R10
  AST_ROW_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_push && $past(scan_push)) |-> scan_word[WORD_W-1 -: ROW_W] >= $past(scan_word[WORD_W-1 -: ROW_W])); // R6
  AST_HIT_MARKS_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && |hit) |=> |flg_q[CF_HALO-1]); // R3
endmodule

// File: tb/test_cf_cluster_finder.sv
module test_cf_cluster_finder;
  localparam int NC = 16, NR = 16, PW = 5, DEPTH = 16, WW = 13;

  logic            clk_i = 0, rst_ni = 0, row_valid_i = 0, rd_en_i = 0;
  logic [NC*PW-1:0] row_data_i = '0;
  logic [6:0]      threshold_i = '0;
  logic [WW-1:0]   rd_data_o;
  logic            empty_o;
  logic [3:0]      overflow_cnt_o;

  cf_cluster_finder i_cf_cluster_finder (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, rx_cnt = 0;
  bit mon_en = 0, done = 0;
  logic [WW-1:0] exp_q [$];
  int img [NR][NC];

  task automatic chk(bit ok, string req, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    rd_en_i = 0;
    if (mon_en && rst_ni && !empty_o) begin
      rd_en_i = 1;
      rx_cnt++;
      if (exp_q.size() == 0) chk(0, "R7 extra word", int'(rd_data_o), -1);
      else begin
        logic [WW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data_o == e, "R6 word", int'(rd_data_o), int'(e));
      end
    end
  end

  // independent frame model: hits, 7x7 union, row/col ordering
  task automatic expect_frame(int thr);
    bit fl [NR][NC];
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) fl[r][c] = 0;
    for (int r = 0; r < NR - 1; r++)
      for (int c = 0; c < NC - 1; c++)
        if (img[r][c] + img[r][c+1] + img[r+1][c] + img[r+1][c+1] > thr)
          for (int rr = r - 3; rr <= r + 3; rr++)
            for (int cc = c - 3; cc <= c + 3; cc++)
              if (rr >= 0 && rr < NR && cc >= 0 && cc < NC) fl[rr][cc] = 1;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        if (fl[r][c]) exp_q.push_back({4'(r), 4'(c), 5'(img[r][c])});
  endtask

  task automatic send_frame(int thr);
    threshold_i = 7'(thr);
    rx_cnt = 0;
    for (int r = 0; r < NR; r++) begin
      @(negedge clk_i);
      for (int c = 0; c < NC; c++) row_data_i[c*PW +: PW] = 5'(img[r][c]);
      row_valid_i = 1;
      @(negedge clk_i);
      row_valid_i = 0;
      repeat (NC + 2) @(negedge clk_i);
    end
    repeat (200) @(negedge clk_i);
  endtask

  task automatic clear_img();
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) img[r][c] = 0;
  endtask

  task automatic block(int r, int c, int v);
    img[r][c] = v; img[r][c+1] = v; img[r+1][c] = v; img[r+1][c+1] = v;
  endtask

  task automatic run(int thr, string req, int exp_words);
    expect_frame(thr);
    send_frame(thr);
    chk(exp_q.size() == 0, {req, " missing words"}, exp_q.size(), 0);
    if (exp_words >= 0) chk(rx_cnt == exp_words, {req, " word count"}, rx_cnt, exp_words);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(empty_o == 1, "R1 empty in reset", empty_o, 1);
    rst_ni = 1;
    @(negedge clk_i);
    chk(empty_o == 1, "R1 empty", empty_o, 1);
    chk(overflow_cnt_o == 0, "R1 overflow", overflow_cnt_o, 0);
    mon_en = 1;

    clear_img(); run(10, "R7 no hits", 0);
    clear_img(); block(7, 7, 5); run(20, "R2 equal sum", 0);
    clear_img(); block(7, 7, 5); run(19, "R3 single window", 49);
    clear_img(); block(0, 0, 31); block(14, 14, 31); run(100, "R4 corners", 41);
    clear_img(); block(4, 4, 31); block(6, 6, 31); run(100, "R5 overlap", 73);
    clear_img(); for (int c = 3; c < 5; c++) img[NR-1][c] = 31; run(70, "R8 frame end", 0);
    clear_img(); for (int c = 3; c < 5; c++) img[0][c] = 31; run(70, "R8 frame start", 0);
    for (int f = 0; f < 3; f++) begin
      for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) img[r][c] = $urandom_range(0, 3);
      block($urandom_range(0, NR - 2), $urandom_range(0, NC - 2), 28);
      block($urandom_range(0, NR - 2), $urandom_range(0, NC - 2), 28);
      run(90, "R10 mixed frame", -1);
    end

    // R9: FIFO fills while nobody reads
    mon_en = 0;
    @(negedge clk_i);
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) img[r][c] = (r * 7 + c) % 32;
    expect_frame(0);
    while (exp_q.size() > DEPTH) void'(exp_q.pop_back());
    send_frame(0);
    chk(overflow_cnt_o == 15, "R9 saturated drop count", overflow_cnt_o, 15);
    chk(empty_o == 0, "R11 words held", empty_o, 0);
    rx_cnt = 0;
    mon_en = 1;
    repeat (40) @(negedge clk_i);
    chk(exp_q.size() == 0, "R9 kept words", exp_q.size(), 0);
    chk(rx_cnt == DEPTH, "R11 read count", rx_cnt, DEPTH);
    chk(empty_o == 1, "R11 empty after reads", empty_o, 1);
    chk(overflow_cnt_o == 15, "R9 count holds", overflow_cnt_o, 15);

    done = 1;
    finish_run();
  end
endmodule